// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by walking a radix page table held in memory. A requester hands it a virtual address together with the physical base of the top-level table. The walker then fetches one 8-byte entry per level over a read port that has a request/response handshake. The virtual page number is cut into equal index slices, and the most significant slice selects the entry in the top-level table. Each valid non-final entry supplies the 4 KB-aligned base of the table one level down. The final entry supplies the physical page number, and the walker joins that number with the untouched 12-bit page offset.

If any entry it reads has its valid bit clear, the walk stops at once. The walker then reports a fault and the level at which the walk failed, and it gives no address. The block keeps no entries between walks and never writes to memory. It handles one walk at a time and has at most one memory read in flight.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, `memReqValid` is 0 and `done` is 0.
- R2: The first read of a walk goes to `ptBase + VPN1*8`, where VPN1 is `reqVa[47:39]`.
- R3: The read for level i (2..4) goes to `(prevEntry[39:12] << 12) + VPNi*8`, where VPNi is the 9-bit slice `reqVa[47-9*(i-1) -: 9]`. Entry bits [63:40] and [11:1] have no effect on any address.
- R4: A walk whose entries are all valid (bit 0 = 1) makes exactly 4 reads and ends with `done`=1, `fault`=0, `faultLevel`=0 and `pa = {lastEntry[39:12], reqVa[11:0]}`.
- R5: If the entry read at level i has bit 0 = 0, the walk makes no further reads and ends with `done`=1, `fault`=1, `faultLevel`=i (1-based) and `pa`=0.
- R6: After a read request is accepted, `memReqValid` stays low until its response has arrived.
- R7: While `memReqValid` is 1 and `memReqReady` is 0, the request stays asserted and `memReqAddr` stays unchanged.
- R8: A new request is accepted only while idle. `reqValid` during a walk is ignored and does not change the addresses that walk reads.
- R9: `done` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request will be taken |
| reqVa | input | 48 | Virtual address to translate |
| ptBase | input | 40 | Physical base of the top-level table |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 40 | Byte address of the entry |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Page table entry |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk ended on an invalid entry |
| faultLevel | output | 3 | Level (1..4) of the invalid entry, 0 on success |
| pa | output | 40 | Translated physical address, 0 on fault |

## Verification
The hardest case to reach is a fault at the final level that arrives after backpressure on the request and a delayed response. Here the walker has already descended three times with the stored virtual address, and it must still abandon the walk without producing an address. The stimulus gets there through a bench memory that follows a per-walk table of expected addresses and entries. The memory can hold `memReqReady` low and delay the response for a chosen number of cycles, and it can clear the valid bit at any chosen level. A separate walk drives `reqValid` with a different address while a walk is in progress, which shows that the captured address alone steers the indexing.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;      // latch a new request
    logic descend;      // move the table base down one level
    logic finishPa;     // complete with a translated address
    logic finishFault;  // complete with an invalid-entry fault
  } walkCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } walkState_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             pteValid,
  output logic             reqReady,
  output logic             memReqValid,
  output logic [LVL_W-1:0] level,
  output walkCmd_t         cmd
);

  walkState_t state;
  logic       lastLevel;

  assign lastLevel   = (level == LVL_W'(LEVELS - 1));
  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);

  always_comb begin
    cmd             = '0;
    cmd.capture     = (state == ST_IDLE) && reqValid;
    cmd.descend     = (state == ST_WAIT) && memRspValid && pteValid && !lastLevel;
    cmd.finishPa    = (state == ST_WAIT) && memRspValid && pteValid && lastLevel;
    cmd.finishFault = (state == ST_WAIT) && memRspValid && !pteValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      level <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_ISSUE;
          level <= '0;
        end
        ST_ISSUE: if (memReqReady) state <= ST_WAIT;
        ST_WAIT: if (memRspValid) begin
          if (cmd.descend) begin
            state <= ST_ISSUE;
            level <= level + LVL_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 64,
  parameter int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  walkCmd_t         cmd,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [PA_W-1:0]  ptBase,
  input  logic [PTE_W-1:0] memRspData,
  output logic [PA_W-1:0]  memReqAddr,
  output logic             pteValid,
  output logic             done,
  output logic             fault,
  output logic [LVL_W-1:0] faultLevel,
  output logic [PA_W-1:0]  pa
);

  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam int PPN_W  = PA_W - OFF_W;

  logic [VA_W-1:0]  vaQ;
  logic [PA_W-1:0]  tableQ;
  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] ppn;
  logic             unusedPteBits;

  assign ppn           = memRspData[PA_W-1:OFF_W];
  assign pteValid      = memRspData[0];
  assign unusedPteBits = ^{memRspData[PTE_W-1:PA_W], memRspData[OFF_W-1:1]};

  // pick the index slice for the current level, top slice first
  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) idx = vaQ[OFF_W + (LEVELS - 1 - l) * IDX_W +: IDX_W];
    end
  end

  assign memReqAddr = tableQ + PA_W'({idx, {ENT_SH{1'b0}}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ        <= '0;
      tableQ     <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      faultLevel <= '0;
      pa         <= '0;
    end else begin
      done <= cmd.finishPa || cmd.finishFault;
      if (cmd.capture) begin
        vaQ    <= reqVa;
        tableQ <= ptBase;
      end
      if (cmd.descend) tableQ <= {ppn, {OFF_W{1'b0}}};
      if (cmd.finishPa) begin
        pa         <= {ppn, vaQ[OFF_W-1:0]};
        fault      <= 1'b0;
        faultLevel <= '0;
      end
      if (cmd.finishFault) begin
        pa         <= '0;
        fault      <= 1'b1;
        faultLevel <= level + LVL_W'(1);
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 64,
  parameter int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [PA_W-1:0]  ptBase,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             done,
  output logic             fault,
  output logic [LVL_W-1:0] faultLevel,
  output logic [PA_W-1:0]  pa
);

  walkCmd_t         cmd;
  logic [LVL_W-1:0] level;
  logic             pteValid;

  pt_walker_ctrl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .pteValid(pteValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .level(level), .cmd(cmd)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .PTE_W(PTE_W), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .level(level), .reqVa(reqVa),
    .ptBase(ptBase), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .pteValid(pteValid), .done(done), .fault(fault),
    .faultLevel(faultLevel), .pa(pa)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [PA_W-1:0]  memReqAddr,
  input logic             memRspValid,
  input logic             done,
  input logic             fault,
  input logic [LVL_W-1:0] faultLevel,
  input logic [PA_W-1:0]  pa
);

  logic inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= 1'b0;
    else if (memReqValid && memReqReady) inFlight <= 1'b1;
    else if (memRspValid) inFlight <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !memReqValid); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R8
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> pa == '0 && faultLevel >= LVL_W'(1) && faultLevel <= LVL_W'(LEVELS)); // R5
  AST_CLEAN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    done && !fault |-> faultLevel == '0); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
  .done(done), .fault(fault), .faultLevel(faultLevel), .pa(pa)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS     = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVa = '0;
  logic [39:0] ptBase = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [39:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done;
  logic        fault;
  logic [2:0]  faultLevel;
  logic [39:0] pa;

  typedef struct {
    logic        f;
    logic [2:0]  lvl;
    logic [39:0] pa;
    int          reads;
  } exp_t;

  exp_t        expQ[$];
  logic [39:0] tAddr[LEVELS];
  logic [63:0] tPte[LEVELS];
  int memIdx = 0;
  int stallCfg = 0;
  int latCfg = 0;
  int doneCount = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .ptBase(ptBase), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done),
    .fault(fault), .faultLevel(faultLevel), .pa(pa)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: follows the per-walk table, checks addresses (R2, R3, R6, R7)
  initial begin
    logic [39:0] held;
    logic [63:0] data;
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        for (int s = 0; s < stallCfg; s++) begin
          held = memReqAddr;
          @(negedge clk);
          check(memReqValid && memReqAddr == held, "R7", "held request",
                {23'b0, memReqValid, memReqAddr}, {24'b1, held});
        end
        memReqReady = 1'b1;
        if (memIdx < LEVELS) begin
          check(memReqAddr == tAddr[memIdx], memIdx == 0 ? "R2" : "R3", "entry address",
                memReqAddr, tAddr[memIdx]);
          data = tPte[memIdx];
        end else begin
          check(1'b0, "R4", "read beyond last level", memIdx, LEVELS);
          data = '0;
        end
        memIdx++;
        @(negedge clk);
        memReqReady = 1'b0;
        check(!memReqValid, "R6", "request while waiting", memReqValid, 0);
        for (int d = 0; d < latCfg; d++) begin
          @(negedge clk);
          check(!memReqValid, "R6", "request while waiting", memReqValid, 0);
        end
        memRspValid = 1'b1;
        memRspData  = data;
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData  = '0;
      end
    end
  end

  // monitor: scoreboard compare on done (R4, R5, R9)
  initial begin
    bit prevDone = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (prevDone && done) check(1'b0, "R9", "done longer than one cycle", 1, 0);
      prevDone = done;
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(fault == e.f, e.f ? "R5" : "R4", "fault flag", fault, e.f);
          check(faultLevel == e.lvl, e.f ? "R5" : "R4", "fault level", faultLevel, e.lvl);
          check(pa == e.pa, e.f ? "R5" : "R4", "physical address", pa, e.pa);
          check(memIdx == e.reads, e.f ? "R5" : "R4", "read count", memIdx, e.reads);
        end
        doneCount++;
      end
    end
  end

  task automatic runWalk(input logic [47:0] va, input logic [39:0] base, input int faultAt,
                         input int stall, input int lat, input bit junk, input int tag);
    logic [39:0] cur;
    logic [27:0] ppn;
    logic [8:0]  idx;
    exp_t        e;
    int          startCount;
    cur = base;
    ppn = '0;
    for (int l = 0; l < LEVELS; l++) begin
      idx      = va[12 + (LEVELS - 1 - l) * 9 +: 9];
      tAddr[l] = cur + {28'b0, idx, 3'b000};
      ppn      = 28'h00A_0000 + 28'(l) * 28'h111 + 28'(tag);
      tPte[l]  = {24'hABCDEF, ppn, 11'h2A5, (faultAt == l + 1) ? 1'b0 : 1'b1};
      cur      = {ppn, 12'h000};
    end
    e.f     = (faultAt != 0);
    e.lvl   = 3'(faultAt);
    e.pa    = (faultAt != 0) ? 40'b0 : {ppn, va[11:0]};
    e.reads = (faultAt != 0) ? faultAt : LEVELS;
    memIdx   = 0;
    stallCfg = stall;
    latCfg   = lat;
    expQ.push_back(e);
    startCount = doneCount;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqVa    = va;
    ptBase   = base;
    @(negedge clk);
    reqValid = 1'b0;
    if (junk) begin
      reqValid = 1'b1;
      reqVa    = ~va;
      ptBase   = 40'hFF_FFFF_F000;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check(!reqReady, "R8", "ready while busy", reqReady, 0);
      end
      reqValid = 1'b0;
    end
    while (doneCount == startCount) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(negedge clk);
    if (!finished) begin
      check(1'b0, "R4", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check(memReqValid == 1'b0, "R1", "memReqValid after reset", memReqValid, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && !memReqValid && !done, "R1", "idle after release",
          {reqReady, memReqValid, done}, 3'b100);

    runWalk(48'h0000_1234_5ABC, 40'h00_1234_5000, 0, 0, 0, 0, 1);   // R4 plain walk
    runWalk(48'hFFFF_FFFF_FFFF, 40'h00_8000_0000, 0, 2, 3, 0, 2);   // R3 top indices, stalls
    runWalk(48'h0000_0000_0000, 40'h00_0000_1000, 0, 1, 0, 0, 3);   // R2 zero indices
    runWalk(48'h7654_3210_FEDC, 40'h00_2222_3000, 1, 0, 1, 0, 4);   // R5 fault at level 1
    runWalk(48'h0A5A_5A5A_5123, 40'h00_3333_4000, 3, 3, 2, 0, 5);   // R5 fault at level 3
    runWalk(48'hDEAD_BEEF_CAFE, 40'h00_4444_5000, 4, 2, 4, 0, 6);   // R5 fault at last level
    runWalk(48'h1357_9BDF_0246, 40'h00_5555_6000, 0, 1, 1, 1, 7);   // R8 request while busy
    runWalk(48'h0001_FF00_0FFF, 40'h00_6666_7000, 2, 0, 0, 0, 8);   // R5 fault at level 2
    runWalk(48'h0001_FF00_0FFF, 40'h00_6666_7000, 0, 0, 0, 0, 9);   // R4 right after fault

    check(expQ.size() == 0, "R9", "pending expectations", expQ.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule